// File: doc/BRIEF.md
# FIFO Service Interrupt Controller

This block decides when a parallel-port FIFO asks the processor for service. Software owns a single mask bit, the service bit. While the service bit is set, the block raises no interrupt and holds the DMA enable low. When software clears the service bit, the block arms. The next qualifying event raises a level interrupt, and the block sets the service bit again by itself, so only one interrupt is raised per arming.

The qualifying event depends on the transfer mode. With DMA selected, the event is a terminal-count pulse from the DMA controller. Under programmed I/O, the event is a threshold condition on the FIFO:

- In the read direction, the condition is that the fill level is at or above the threshold.
- In the write direction, the condition is that the free space is at or above the threshold.

If that condition already holds when software re-arms, the interrupt follows at once, even though no byte has crossed the threshold.

Software acknowledges the interrupt by writing the service bit. Writing 0 acknowledges and re-arms. Writing 1 acknowledges and leaves the block masked. FIFO storage, bus decoding and the register file are outside this block.

Top module: `fifo_svc_irq`

The controller is a three-state machine:

- MASKED: the service bit is 1 and the status bit is 0.
- ARMED: the service bit is 0.
- FIRED: the service bit is 1, and the status bit and interrupt are 1.

The transitions are:

- RST to MASKED on reset.
- ARM: MASKED to ARMED on a write of 0.
- FIRE: ARMED to FIRED when the condition holds.
- MASK: ARMED to MASKED on a write of 1.
- ACK_REARM: FIRED to ARMED on a write of 0.
- ACK_MASK: FIRED to MASKED on a write of 1.

In every state, a software write takes priority over the condition.

## Requirements
- R1: After a synchronous reset, `svc_bit` is 1, `irq` is 0 and `dma_go` is 0.
- R2: A write (`svc_wr`=1) with `svc_wdata`=0 makes `svc_bit` read 0 after the next clock edge, and `irq` is 0 in that cycle.
- R3: While `svc_bit` is 1 and `irq` is 0, no terminal-count pulse and no threshold condition raises `irq`.
- R4: While armed, with `dma_en`=1, a cycle with `dma_tc`=1 raises `irq` after that edge; in this mode the threshold condition has no effect.
- R5: While armed, with `dma_en`=0 and `dir_rd`=1, `irq` rises after the first edge at which `fifo_level` >= `thresh`.
- R6: While armed, with `dma_en`=0 and `dir_rd`=0, `irq` rises after the first edge at which DEPTH - `fifo_level` >= `thresh`. With `dma_en`=0, `dma_tc` has no effect.
- R7: When `irq` rises, `svc_bit` is 1 in the same cycle, and `irq` stays 1 until a software write.
- R8: Re-arming while the selected condition already holds raises `irq` one edge after `svc_bit` reads 0.
- R9: Any software write clears `irq` after its edge, and `svc_bit` takes the written value; a write takes priority over a condition in the same cycle.
- R10: `dma_go` equals `dma_en` AND NOT `svc_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_wr | input | 1 | Software write strobe for the service bit |
| svc_wdata | input | 1 | Value written to the service bit |
| dma_en | input | 1 | 1 selects DMA mode, 0 selects programmed I/O |
| dma_tc | input | 1 | DMA terminal-count pulse |
| dir_rd | input | 1 | 1 selects the read direction (peripheral to host) |
| fifo_level | input | LW | FIFO fill level, 0 to DEPTH bytes |
| thresh | input | LW | Service threshold in bytes |
| svc_bit | output | 1 | Current service (mask) bit |
| irq | output | 1 | Level interrupt request, equal to the status bit |
| dma_go | output | 1 | Gated DMA enable |

## Verification
The state is the only register on any path. A write or a condition presented before a rising edge shows on `svc_bit` and `irq` just after that edge. `dma_go` follows `dma_en` in the same cycle from the current state. The bench drives every input at the falling edge, advances the model at the rising edge, and compares all three outputs one nanosecond later. In that window, neither the inputs nor the state can change.

A re-arm with the condition already true therefore shows `irq` two edges after the write: one edge to reach ARMED and one edge to fire. The directed cases sample exactly there.

// File: rtl/fifo_svc_pkg.sv
package fifo_svc_pkg;
    typedef enum logic [1:0] {
        ST_MASKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FIRED  = 2'd2
    } svc_state_t;
endpackage

// File: rtl/fifo_svc_cond.sv
// Selects and evaluates the service condition for the current mode.
module fifo_svc_cond #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          dma_en,
    input  logic          dma_tc,
    input  logic          dir_rd,
    input  logic [LW-1:0] fifo_level,
    input  logic [LW-1:0] thresh,
    output logic          cond
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [LW-1:0] free_space;
    logic          pio_hit;

    always_comb begin
        free_space = DEPTH_L - fifo_level;
        if (dir_rd) begin
            pio_hit = (fifo_level >= thresh);
        end else begin
            pio_hit = (free_space >= thresh);
        end
        cond = dma_en ? dma_tc : pio_hit;
    end
endmodule

// File: rtl/fifo_svc_fsm.sv
// Arming state machine: state register and output decode.
module fifo_svc_fsm
    import fifo_svc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic svc_wr,
    input  logic svc_wdata,
    input  logic cond,
    input  logic dma_en,
    output logic svc_bit,
    output logic irq,
    output logic dma_go
);
    svc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED: begin
                if (svc_wr && !svc_wdata) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (svc_wr) begin
                    state_d = svc_wdata ? ST_MASKED : ST_ARMED;
                end else if (cond) begin
                    state_d = ST_FIRED;
                end
            end
            ST_FIRED: begin
                if (svc_wr) state_d = svc_wdata ? ST_MASKED : ST_ARMED;
            end
            default: state_d = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MASKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        svc_bit = (state_q != ST_ARMED);
        irq     = (state_q == ST_FIRED);
        dma_go  = dma_en && (state_q == ST_ARMED);
    end
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          svc_wr,
    input  logic          svc_wdata,
    input  logic          dma_en,
    input  logic          dma_tc,
    input  logic          dir_rd,
    input  logic [LW-1:0] fifo_level,
    input  logic [LW-1:0] thresh,
    output logic          svc_bit,
    output logic          irq,
    output logic          dma_go
);
    logic cond;

    fifo_svc_cond #(.DEPTH(DEPTH), .LW(LW)) u_cond (
        .dma_en     (dma_en),
        .dma_tc     (dma_tc),
        .dir_rd     (dir_rd),
        .fifo_level (fifo_level),
        .thresh     (thresh),
        .cond       (cond)
    );

    fifo_svc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_wr    (svc_wr),
        .svc_wdata (svc_wdata),
        .cond      (cond),
        .dma_en    (dma_en),
        .svc_bit   (svc_bit),
        .irq       (irq),
        .dma_go    (dma_go)
    );
endmodule

// File: rtl/fifo_svc_irq_chk.sv
module fifo_svc_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic svc_wr,
    input logic svc_wdata,
    input logic dma_en,
    input logic dma_tc,
    input logic svc_bit,
    input logic irq
);
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_bit && !irq && !svc_wr) |=> !irq);

    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && !svc_wdata) |=> !svc_bit);

    p_tc_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_bit && dma_en && dma_tc && !svc_wr) |=> irq);

    p_fire_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> svc_bit);

    p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc_wr) |=> irq);

    p_write_acks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr |=> !irq);
endmodule

bind fifo_svc_irq fifo_svc_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_wr    (svc_wr),
    .svc_wdata (svc_wdata),
    .dma_en    (dma_en),
    .dma_tc    (dma_tc),
    .svc_bit   (svc_bit),
    .irq       (irq)
);

// File: tb/fifo_svc_irq_bench.sv
module fifo_svc_irq_bench;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          svc_wr = 1'b0, svc_wdata = 1'b0;
    logic          dma_en = 1'b0, dma_tc = 1'b0, dir_rd = 1'b0;
    logic [LW-1:0] fifo_level = '0, thresh = '0;
    logic          svc_bit, irq, dma_go;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_svc = 1'b1;
    bit m_irq = 1'b0;

    always #4 clk = ~clk;

    fifo_svc_irq #(.DEPTH(DEPTH), .LW(LW)) u_fifo_svc_irq (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_wdata(svc_wdata),
        .dma_en(dma_en), .dma_tc(dma_tc), .dir_rd(dir_rd),
        .fifo_level(fifo_level), .thresh(thresh),
        .svc_bit(svc_bit), .irq(irq), .dma_go(dma_go)
    );

    function automatic bit cond_f(bit de, bit tc, bit rd, int lvl, int thr);
        if (de) return tc;
        if (rd) return lvl >= thr;
        return (DEPTH - lvl) >= thr;
    endfunction

    task automatic cmp(string tag, string what, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "svc_bit", svc_bit, m_svc);
        cmp(tag, "irq", irq, m_irq);
        cmp("R10", "dma_go", dma_go, dma_en & ~m_svc);
    endtask

    task automatic step(bit wr, bit wd, bit de, bit tc, bit rd, int lvl, int thr, string tag);
        @(negedge clk);
        svc_wr = wr; svc_wdata = wd; dma_en = de; dma_tc = tc; dir_rd = rd;
        fifo_level = LW'(lvl); thresh = LW'(thr);
        @(posedge clk);
        if (wr) begin
            m_irq = 1'b0;
            m_svc = wd;
        end else if (!m_svc && cond_f(de, tc, rd, lvl, thr)) begin
            m_irq = 1'b1;
            m_svc = 1'b1;
        end
        #1;
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1");
        // R3: masked, terminal count and a true threshold do nothing
        step(0, 0, 1, 1, 1, 8, 2, "R3");
        step(0, 0, 0, 0, 1, 16, 1, "R3");
        // R2: arm in DMA mode without terminal count
        step(1, 0, 1, 0, 1, 16, 1, "R2");
        step(0, 0, 1, 0, 1, 16, 1, "R4");   // threshold ignored in DMA mode
        step(0, 0, 1, 1, 1, 0, 9, "R4");    // terminal count fires
        step(0, 0, 1, 0, 1, 0, 9, "R7");    // level held
        step(0, 0, 0, 0, 1, 0, 9, "R7");
        // R8: re-arm with read condition already true
        step(1, 0, 0, 0, 1, 10, 4, "R8");
        step(0, 0, 0, 0, 1, 10, 4, "R8");
        // R9: acknowledge masked
        step(1, 1, 0, 0, 1, 10, 4, "R9");
        // R5: read direction crosses threshold
        step(1, 0, 0, 0, 1, 3, 4, "R5");
        step(0, 0, 0, 1, 1, 3, 4, "R6");    // tc ignored in PIO mode
        step(0, 0, 0, 0, 1, 4, 4, "R5");
        // R6: write direction uses free space
        step(1, 0, 0, 0, 0, 13, 4, "R6");
        step(0, 0, 0, 0, 0, 12, 4, "R6");
        // R9: write priority over condition
        step(1, 0, 0, 0, 0, 0, 4, "R9");
        step(1, 0, 0, 0, 0, 0, 4, "R9");
        step(1, 1, 0, 0, 0, 0, 4, "R9");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 6) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
                 $urandom % 2, $urandom % (DEPTH + 1), $urandom % (DEPTH + 1), "R7");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule